// File: doc/BRIEF.md
# Asynchronous Input Conditioning Stage

This block takes a vector of digital signals that change with no relation to the local clock and turns each one into clean, clock-aligned information. Every channel passes, in order, through a multi-flop synchroniser, a run-length glitch filter, an edge detector that emits a one-clock event pulse, and a pulse stretcher that holds a wider version of that event for a fixed number of clocks.

A typical use is conditioning trigger lines, buttons or external strobes before they reach control logic. Downstream logic may watch the filtered level, react to the single-cycle event, or use the stretched pulse to drive something that needs a longer assertion. All channels share one clock and one synchronous active-low reset; the channel count, synchroniser depth, filter length, stretch length and the detected edge polarity are elaboration parameters.

Top module: `async_input_conditioner`

## Requirements
- R1: A clean change on a raw input appears on `level_out` exactly SYNC_STAGES + FILTER_LEN rising clock edges after the first edge that samples the new value (SYNC_STAGES defaults to 2 and must be at least 2).
- R2: `level_out` takes a new value only after the synchronised input has differed from it on FILTER_LEN consecutive edges; a pulse that lasts fewer than FILTER_LEN edges leaves all outputs of that channel at 0, and any return to the current level restarts the count.
- R3: A pulse lasting W >= FILTER_LEN edges produces a `level_out` high for exactly W cycles.
- R4: With the edge-select parameter set to rising (the default), `pulse_out` is high for exactly one cycle, in the first cycle in which `level_out` is 1 after having been 0.
- R5: With the edge-select parameter set to falling, `pulse_out` is high for exactly one cycle, in the first cycle in which `level_out` is 0 after having been 1, and never on the rising edge.
- R6: `stretch_out` goes high in the same cycle as `pulse_out` and stays high for exactly STRETCH_LEN cycles.
- R7: An event that occurs while `stretch_out` is high restarts the stretch: the output stays high with no gap until STRETCH_LEN cycles after the newest event.
- R8: While `rst_n` is 0 at a rising clock edge, all outputs are 0 in the following cycle, whatever the raw inputs do, and a stretch in progress is cancelled.
- R9: Channels are independent: activity on one channel never changes another channel's outputs.
- R10: With FILTER_LEN = 1 the filter adds one cycle of latency and rejects nothing: a one-edge input pulse gives a one-cycle `level_out` pulse SYNC_STAGES + 1 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | CHANNELS | Asynchronous raw inputs, one bit per channel |
| level_out | output | CHANNELS | Synchronised and glitch-filtered level |
| pulse_out | output | CHANNELS | One-clock event on the selected edge of the filtered level |
| stretch_out | output | CHANNELS | Event pulse held for STRETCH_LEN clocks, retriggerable |

## Verification
A wrong internal state here shows up within a few cycles as a timing error at the ports: a filter counter that miscounts moves the `level_out` edge by one or more cycles, or lets a short pulse through, and that is visible at the exact cycle the level is expected to change. A stuck edge-history flop yields a missing, doubled or wrong-polarity `pulse_out`, and a stretch counter that loads or decrements wrongly changes the length of `stretch_out`, which the bench measures cycle by cycle for every pulse width from one edge up to well past the filter length, with several channels active at once and a retrigger inside an active stretch.

// File: rtl/async_cond_pkg.sv
// Package: shared types for the asynchronous input conditioning stage.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package async_cond_pkg;

    // Which transition of the filtered level counts as an event.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/cond_sync_chain.sv
// Module: cond_sync_chain
// Brings one asynchronous bit into the clk domain through a shift chain of
// STAGES flops. Assumes STAGES >= 2 and that the consumer uses only the
// last stage. Reset is synchronous, active low, and clears every stage.
module cond_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    // Shift the raw input one stage further per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[TOP-1:0], d};
        end
    end

    assign q = chain[TOP];

endmodule

// File: rtl/cond_run_filter.sv
// Module: cond_run_filter
// Run-length glitch filter: the output level adopts the input value only
// after the input has differed from it on LENGTH consecutive clocks. Any
// clock where input equals the output restarts the run. Assumes a
// synchronous input and LENGTH >= 1.
module cond_run_filter #(
    parameter int LENGTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic level
);

    localparam int CW = (LENGTH > 1) ? $clog2(LENGTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(LENGTH - 1);

    logic [CW-1:0] run;

    // Count consecutive mismatches and flip the level when the run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            run   <= '0;
        end else if (sync_in == level) begin
            run <= '0;
        end else if (run == LAST) begin
            level <= sync_in;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R2: the level only moves towards a differing input value.
    assert_level_moves_on_mismatch_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(sync_in) != $past(level))
    );

endmodule

// File: rtl/cond_pulse_shaper.sv
// Module: cond_pulse_shaper
// Detects the selected edge of the filtered level, emits a one-clock event
// and a retriggerable stretched pulse of STRETCH_LEN clocks that starts in
// the event cycle. Assumes a clean, synchronous level and STRETCH_LEN >= 1.
module cond_pulse_shaper
    import async_cond_pkg::*;
#(
    parameter edge_sel_e EDGE_MODE   = EDGE_RISE,
    parameter int        STRETCH_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse,
    output logic stretch
);

    localparam int EW = $clog2(STRETCH_LEN + 1);
    localparam logic [EW-1:0] RELOAD = EW'(STRETCH_LEN - 1);

    logic          prev;
    logic          event_now;
    logic [EW-1:0] remain;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= level;
        end
    end

    // Pick the edge polarity at elaboration time.
    generate
        if (EDGE_MODE == EDGE_RISE) begin : g_rise
            assign event_now = level & ~prev;
        end else begin : g_fall
            assign event_now = ~level & prev;
        end
    endgenerate

    // Load the remaining stretch on each event, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (event_now) begin
            remain <= RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign pulse   = event_now;
    assign stretch = event_now | (remain != '0);

    // R4: an event never lasts more than one cycle.
    assert_single_cycle_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse
    );

    // R7: the stretched output only starts from an event.
    assert_stretch_from_event_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(stretch) |-> pulse
    );

    generate
        if (STRETCH_LEN > 1) begin : g_hold_chk
            // R6: a stretch longer than one cycle is still high after the event.
            assert_stretch_holds_R6: assert property (
                @(posedge clk) disable iff (!rst_n)
                pulse |=> stretch
            );
        end
    endgenerate

endmodule

// File: rtl/async_input_conditioner.sv
// Module: async_input_conditioner (top)
// Conditions CHANNELS asynchronous inputs: synchroniser, run-length glitch
// filter, edge event and retriggerable stretch per channel. Assumes one
// clock for all channels and a synchronous active-low reset that clears
// every output.
module async_input_conditioner
    import async_cond_pkg::*;
#(
    parameter int        CHANNELS    = 4,
    parameter int        SYNC_STAGES = 2,
    parameter int        FILTER_LEN  = 4,
    parameter int        STRETCH_LEN = 8,
    parameter edge_sel_e EDGE_MODE   = EDGE_RISE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] raw_in,
    output logic [CHANNELS-1:0] level_out,
    output logic [CHANNELS-1:0] pulse_out,
    output logic [CHANNELS-1:0] stretch_out
);

    logic [CHANNELS-1:0] synced;

    // One independent conditioning path per channel.
    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
            cond_sync_chain #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw_in[ch]),
                .q     (synced[ch])
            );

            cond_run_filter #(
                .LENGTH (FILTER_LEN)
            ) u_filter (
                .clk     (clk),
                .rst_n   (rst_n),
                .sync_in (synced[ch]),
                .level   (level_out[ch])
            );

            cond_pulse_shaper #(
                .EDGE_MODE   (EDGE_MODE),
                .STRETCH_LEN (STRETCH_LEN)
            ) u_shape (
                .clk     (clk),
                .rst_n   (rst_n),
                .level   (level_out[ch]),
                .pulse   (pulse_out[ch]),
                .stretch (stretch_out[ch])
            );
        end
    endgenerate

    // R8: a reset edge leaves every output cleared.
    assert_reset_clears_R8: assert property (
        @(posedge clk)
        !rst_n |=> (level_out == '0 && pulse_out == '0 && stretch_out == '0)
    );

endmodule

// File: tb/async_input_conditioner_test.sv
`timescale 1ns/1ps
module async_input_conditioner_test;
    import async_cond_pkg::*;

    localparam int N = 4;
    localparam int S = 2;
    localparam int L = 3;
    localparam int E = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] raw = '0;

    logic [N-1:0] lvl_r, pul_r, str_r;
    logic [N-1:0] lvl_f, pul_f, str_f;
    logic [N-1:0] lvl_1, pul_1, str_1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    async_input_conditioner #(
        .CHANNELS(N), .SYNC_STAGES(S), .FILTER_LEN(L), .STRETCH_LEN(E),
        .EDGE_MODE(EDGE_RISE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw),
        .level_out(lvl_r), .pulse_out(pul_r), .stretch_out(str_r)
    );

    async_input_conditioner #(
        .CHANNELS(N), .SYNC_STAGES(S), .FILTER_LEN(L), .STRETCH_LEN(E),
        .EDGE_MODE(EDGE_FALL)
    ) uut_fall (
        .clk(clk), .rst_n(rst_n), .raw_in(raw),
        .level_out(lvl_f), .pulse_out(pul_f), .stretch_out(str_f)
    );

    async_input_conditioner #(
        .CHANNELS(N), .SYNC_STAGES(S), .FILTER_LEN(1), .STRETCH_LEN(E),
        .EDGE_MODE(EDGE_RISE)
    ) uut_l1 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw),
        .level_out(lvl_1), .pulse_out(pul_1), .stretch_out(str_1)
    );

    task automatic check(input logic got, input logic exp, input string req,
                         input string what, input int ch, input int k);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s ch=%0d k=%0d actual=%b expected=%b",
                     req, what, ch, k, got, exp);
        end
    endtask

    function automatic logic in_win(input int k, input int lo, input int hi);
        return (k >= lo) && (k <= hi);
    endfunction

    task automatic idle(input int n);
        raw = '0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Channel c is driven high for width[c] edges, then low; all outputs
    // are checked every cycle against arithmetic windows.
    task automatic width_round(input int w0, input int w1, input int w2,
                               input int w3);
        int w [N];
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        for (int k = 1; k <= 40; k++) begin
            for (int c = 0; c < N; c++) raw[c] = (k <= w[c]);
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < N; c++) begin
                logic ok;
                ok = (w[c] >= L);
                // R1 R2 R3 R9: level window per channel
                check(lvl_r[c], ok && in_win(k, S + L, S + L + w[c] - 1),
                      "R1/R2/R3/R9", "level", c, k);
                // R4: one-cycle rising event
                check(pul_r[c], ok && (k == S + L), "R4", "pulse", c, k);
                // R6: stretch length
                check(str_r[c], ok && in_win(k, S + L, S + L + E - 1),
                      "R6", "stretch", c, k);
                // R5: falling-edge event
                check(pul_f[c], ok && (k == S + L + w[c]), "R5", "pulse_fall", c, k);
                check(str_f[c], ok && in_win(k, S + L + w[c], S + L + w[c] + E - 1),
                      "R5", "stretch_fall", c, k);
                // R10: filter length 1 passes everything with one cycle
                check(lvl_1[c], in_win(k, S + 1, S + w[c]), "R10", "level_l1", c, k);
                check(pul_1[c], (k == S + 1), "R10", "pulse_l1", c, k);
            end
        end
        idle(5);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: reset with all raw inputs high keeps outputs at 0
        rst_n = 1'b0;
        raw = '1;
        @(negedge clk);
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < N; c++) begin
                check(lvl_r[c], 1'b0, "R8", "level_in_reset", c, k);
                check(pul_r[c], 1'b0, "R8", "pulse_in_reset", c, k);
                check(str_r[c], 1'b0, "R8", "stretch_in_reset", c, k);
            end
        end
        raw = '0;
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R2 sweep: widths 1..4 (1 and 2 rejected), then 5..8
        width_round(1, 2, 3, 4);
        width_round(5, 6, 7, 8);
        width_round(2, 9, 1, 12);

        // R7: two accepted pulses on channel 0 six cycles apart
        for (int k = 1; k <= 30; k++) begin
            raw = '0;
            raw[0] = in_win(k, 1, 3) || in_win(k, 7, 9);
            @(posedge clk);
            @(negedge clk);
            check(lvl_r[0], in_win(k, 5, 7) || in_win(k, 11, 13), "R7", "level", 0, k);
            check(pul_r[0], (k == 5) || (k == 11), "R7", "pulse", 0, k);
            check(str_r[0], in_win(k, 5, 18), "R7", "stretch_retrigger", 0, k);
            check(str_f[0], in_win(k, 8, 21), "R7", "stretch_fall_retrigger", 0, k);
            for (int c = 1; c < N; c++)
                check(str_r[c], 1'b0, "R9", "idle_channel", c, k);
        end
        idle(5);

        // R8: reset in the middle of an active stretch clears it
        for (int k = 1; k <= 6; k++) begin
            raw = '1;
            @(posedge clk);
            @(negedge clk);
        end
        for (int c = 0; c < N; c++)
            check(str_r[c], 1'b1, "R6", "stretch_before_reset", c, 6);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            check(lvl_r[c], 1'b0, "R8", "level_after_reset", c, 7);
            check(str_r[c], 1'b0, "R8", "stretch_after_reset", c, 7);
        end
        raw = '0;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule